// File: doc/BRIEF.md
# Signed/Unsigned Arithmetic Unit with Residue-3 Reduction

This block is an arithmetic unit for two operands, eight bits wide by default. A four-bit function code selects the operation. The unit can forward either operand unchanged. It can add or subtract the operands as unsigned numbers or as two's-complement numbers. It can also reduce the first operand modulo 3 under either reading. The top bit of the function code selects the signed interpretation. The map is sparse, and every code outside it yields zero.

Alongside the result, the unit returns two flags. The overflow flag reports a result that does not fit in the operand width. The negative flag reports that the exact mathematical result is below zero, which display logic further down the path can use. The residue is computed with small adders that fold two-bit digit groups, and no divider is used. All outputs are registered once, so a function code and its operands presented before a rising clock edge appear at the outputs just after that edge.

Top module: `alu_m3_top`

## Requirements
- R1: Code 0000 forwards `op_a` to `res` and code 0001 forwards `op_b`. Both codes return `ovf` = 0 and `neg` = 0.
- R2: Code 0010 returns (`op_a` + `op_b`) mod 256 and sets `ovf` when the unsigned sum exceeds 255. `neg` is 0.
- R3: Code 0011 returns (`op_a` − `op_b`) mod 256. `ovf` and `neg` are both set exactly when `op_b` > `op_a` as unsigned numbers.
- R4: Code 1010 returns the low eight bits of the signed sum. `ovf` is set when the exact sum lies outside −128..127, and `neg` is set when the exact sum is negative.
- R5: Code 1011 returns the low eight bits of the signed difference `op_a` − `op_b`. `ovf` is set when the exact difference lies outside −128..127, and `neg` is set when it is negative.
- R6: Code 0100 returns `op_a` mod 3 (a value of 0, 1 or 2) with `op_a` read as unsigned. `ovf` and `neg` are 0.
- R7: Code 1100 returns the residue in 0..2 that is congruent to `op_a` read as two's complement. For example, 0xFF gives 2 and 0x80 gives 1. `ovf` and `neg` are 0.
- R8: Every code other than the eight listed above returns `res` = 0, `ovf` = 0 and `neg` = 0.
- R9: The outputs show the operation whose inputs were present at the previous rising clock edge. While `rst_n` is low, `res`, `ovf` and `neg` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset; clears the outputs |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| func | input | 4 | Function code; bit 3 selects the signed interpretation |
| res | output | 8 | Registered result |
| ovf | output | 1 | Registered overflow flag |
| neg | output | 1 | Registered flag: the exact result is negative |

## Verification
The add and subtract codes are driven with operand pairs that sit at the unsigned wrap points (0xFF + 0x01, 0x00 − 0x01) and at the signed limits (0x7F + 0x01, 0x80 − 0x01, 0x80 + 0x80). These pairs separate a carry from a signed overflow and a borrow from a negative result that still fits. Both residue codes are run over all 256 values of `op_a`, so every digit pattern of the folding network is covered and the correction applied to negative operands is checked for each sign. A long run of random operands across all sixteen codes confirms that unused codes stay at zero and that changing the code on every cycle never carries a flag into the next result. A reset in the middle of the run checks that the outputs clear.

// File: rtl/alu_m3_pkg.sv
package alu_m3_pkg;

    // Function codes; bit 3 chooses the two's-complement reading.
    typedef enum logic [3:0] {
        FN_PASS_A = 4'b0000,
        FN_PASS_B = 4'b0001,
        FN_UADD   = 4'b0010,
        FN_USUB   = 4'b0011,
        FN_UMOD   = 4'b0100,
        FN_SADD   = 4'b1010,
        FN_SSUB   = 4'b1011,
        FN_SMOD   = 4'b1100
    } func_e;

    // Result source chosen by the decoder.
    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_A,
        SEL_B,
        SEL_ARITH,
        SEL_MOD
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic sub;
        logic sgn;
    } ctrl_t;

endpackage

// File: rtl/alu_m3_decode.sv
module alu_m3_decode
    import alu_m3_pkg::*;
(
    input  logic [3:0] func,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = '{sel: SEL_ZERO, sub: 1'b0, sgn: 1'b0};
        unique case (func)
            FN_PASS_A: ctl.sel = SEL_A;
            FN_PASS_B: ctl.sel = SEL_B;
            FN_UADD:   ctl.sel = SEL_ARITH;
            FN_USUB:   begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; end
            FN_UMOD:   ctl.sel = SEL_MOD;
            FN_SADD:   begin ctl.sel = SEL_ARITH; ctl.sgn = 1'b1; end
            FN_SSUB:   begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; ctl.sgn = 1'b1; end
            FN_SMOD:   begin ctl.sel = SEL_MOD;   ctl.sgn = 1'b1; end
            default:   ctl.sel = SEL_ZERO;
        endcase
    end

endmodule

// File: rtl/alu_m3_addsub.sv
module alu_m3_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         neg
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic         carry;
    logic         s_ovf;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        carry = wide[W];
        // Operands of equal sign giving a result of the other sign.
        s_ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        if (sgn) begin
            ovf = s_ovf;
            neg = sum[W-1] ^ s_ovf;
        end else if (sub) begin
            ovf = ~carry;
            neg = ~carry;
        end else begin
            ovf = carry;
            neg = 1'b0;
        end
    end

endmodule

// File: rtl/alu_m3_mod3.sv
module alu_m3_mod3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         sgn,
    output logic [1:0]   r
);

    // Every group of two bits weighs 4^k, and 4^k leaves residue 1 mod 3.
    localparam int NDIG  = (W + 1) / 2;
    localparam int SW    = $clog2(3 * NDIG + 1);
    localparam int SWE   = SW + (SW % 2);
    localparam int NFOLD = SW;
    // Subtracting 2^W mod 3 is done as adding its complement to 3.
    localparam logic [2:0] SHIFT = (W % 2 == 0) ? 3'd2 : 3'd1;

    logic [2*NDIG-1:0] padded;
    logic [SW-1:0]     digsum;
    logic [SWE-1:0]    acc;
    logic [SWE-1:0]    nxt;
    logic [1:0]        u;
    logic [2:0]        t;

    always_comb begin
        padded        = '0;
        padded[W-1:0] = a;
        digsum        = '0;
        for (int i = 0; i < NDIG; i++) begin
            digsum = digsum + SW'(padded[2*i +: 2]);
        end
        acc = SWE'(digsum);
        for (int k = 0; k < NFOLD; k++) begin
            nxt = '0;
            for (int j = 0; j < SWE / 2; j++) begin
                nxt = nxt + SWE'(acc[2*j +: 2]);
            end
            acc = nxt;
        end
        u = (acc[1:0] == 2'd3) ? 2'd0 : acc[1:0];
        t = {1'b0, u} + SHIFT;
        if (sgn && a[W-1]) begin
            r = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
        end else begin
            r = u;
        end
    end

endmodule

// File: rtl/alu_m3_top.sv
module alu_m3_top
    import alu_m3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   func,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         neg
);

    ctrl_t        ctl;
    logic [W-1:0] as_sum;
    logic         as_ovf;
    logic         as_neg;
    logic [1:0]   m3;
    logic [W-1:0] res_d;
    logic         ovf_d;
    logic         neg_d;

    alu_m3_decode u_dec (
        .func (func),
        .ctl  (ctl)
    );

    alu_m3_addsub #(.W(W)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (ctl.sub),
        .sgn (ctl.sgn),
        .sum (as_sum),
        .ovf (as_ovf),
        .neg (as_neg)
    );

    alu_m3_mod3 #(.W(W)) u_mod3 (
        .a   (op_a),
        .sgn (ctl.sgn),
        .r   (m3)
    );

    // Result selection (combinational side).
    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        neg_d = 1'b0;
        unique case (ctl.sel)
            SEL_A:     res_d = op_a;
            SEL_B:     res_d = op_b;
            SEL_ARITH: begin
                res_d = as_sum;
                ovf_d = as_ovf;
                neg_d = as_neg;
            end
            SEL_MOD:   res_d = {{(W-2){1'b0}}, m3};
            default:   res_d = '0;
        endcase
    end

    // Output register (clocked side).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res <= '0;
            ovf <= 1'b0;
            neg <= 1'b0;
        end else begin
            res <= res_d;
            ovf <= ovf_d;
            neg <= neg_d;
        end
    end

endmodule

// File: rtl/alu_m3_chk.sv
module alu_m3_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   func,
    input logic [W-1:0] res,
    input logic         ovf,
    input logic         neg
);

    logic         prev_live;
    logic [W:0]   wide_sum;
    logic         b_gt_a;
    logic         is_mod;
    logic         is_pass;
    logic         is_known;

    always_ff @(posedge clk) prev_live <= rst_n;

    always_comb begin
        wide_sum = {1'b0, op_a} + {1'b0, op_b};
        b_gt_a   = op_b > op_a;
        is_mod   = (func == 4'b0100) || (func == 4'b1100);
        is_pass  = (func == 4'b0000) || (func == 4'b0001);
        is_known = is_mod || is_pass || (func == 4'b0010) || (func == 4'b0011)
                || (func == 4'b1010) || (func == 4'b1011);
    end

    p_pass_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(is_pass)) |-> (!ovf && !neg));

    p_pass_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(func) == 4'b0000) |-> (res == $past(op_a)));

    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(func) == 4'b0010) |-> (ovf == $past(wide_sum[W]) && !neg));

    p_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(func) == 4'b0011) |-> (ovf == $past(b_gt_a) && neg == $past(b_gt_a)));

    p_sadd_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(func) == 4'b1010 && ovf)
            |-> ($past(op_a[W-1]) == $past(op_b[W-1]) && res[W-1] != $past(op_a[W-1])));

    p_ssub_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(func) == 4'b1011 && ovf)
            |-> ($past(op_a[W-1]) != $past(op_b[W-1]) && res[W-1] != $past(op_a[W-1])));

    p_mod_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(is_mod)) |-> (res < 3 && !ovf && !neg));

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && !$past(is_known)) |-> (res == '0 && !ovf && !neg));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !ovf && !neg));

endmodule

bind alu_m3_top alu_m3_chk #(.W(W)) i_alu_m3_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .func  (func),
    .res   (res),
    .ovf   (ovf),
    .neg   (neg)
);

// File: tb/test_alu_m3_top.sv
module test_alu_m3_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [3:0] func = '0;
    logic [7:0] res;
    logic       ovf;
    logic       neg;

    int checks = 0;
    int fails  = 0;

    int    exp_res = 0;
    bit    exp_ovf = 0;
    bit    exp_neg = 0;
    bit    pending = 0;
    string pend_tag = "";

    always #5 clk = ~clk;

    alu_m3_top i_alu_m3_top (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .func  (func),
        .res   (res),
        .ovf   (ovf),
        .neg   (neg)
    );

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            4'b0000, 4'b0001: return "R1";
            4'b0010: return "R2";
            4'b0011: return "R3";
            4'b1010: return "R4";
            4'b1011: return "R5";
            4'b0100: return "R6";
            4'b1100: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Behavioural reference, integer arithmetic on the requirements.
    task automatic model(input int ua, input int ub, input logic [3:0] f);
        int sa, sb, v;
        sa = (ua >= 128) ? ua - 256 : ua;
        sb = (ub >= 128) ? ub - 256 : ub;
        exp_res = 0; exp_ovf = 0; exp_neg = 0;
        case (f)
            4'b0000: exp_res = ua;
            4'b0001: exp_res = ub;
            4'b0010: begin v = ua + ub; exp_res = v & 255; exp_ovf = (v > 255); end
            4'b0011: begin v = ua - ub; exp_res = v & 255; exp_ovf = (v < 0); exp_neg = (v < 0); end
            4'b1010: begin v = sa + sb; exp_res = v & 255; exp_ovf = (v > 127 || v < -128); exp_neg = (v < 0); end
            4'b1011: begin v = sa - sb; exp_res = v & 255; exp_ovf = (v > 127 || v < -128); exp_neg = (v < 0); end
            4'b0100: exp_res = ua % 3;
            4'b1100: exp_res = ((sa % 3) + 3) % 3;
            default: exp_res = 0;
        endcase
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(res) != exp_res || ovf !== exp_ovf || neg !== exp_neg) begin
            fails++;
            $display("FAIL %s: res=%0d ovf=%0b neg=%0b expected res=%0d ovf=%0b neg=%0b",
                     tag, res, ovf, neg, exp_res, exp_ovf, exp_neg);
        end
    endtask

    // One vector per clock: check the previous one, then drive the next.
    task automatic apply(input int ua, input int ub, input logic [3:0] f);
        @(negedge clk);
        if (pending) compare(pend_tag);
        op_a = 8'(ua); op_b = 8'(ub); func = f;
        model(ua, ub, f);
        pending  = 1;
        pend_tag = tag_of(f);
    endtask

    task automatic flush();
        @(negedge clk);
        if (pending) compare(pend_tag);
        pending = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9: actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        op_a = 8'hA5; op_b = 8'h5A; func = 4'b0010;
        repeat (3) @(negedge clk);
        exp_res = 0; exp_ovf = 0; exp_neg = 0;
        compare("R9");
        rst_n = 1'b1;

        // R1 pass-through
        apply(8'hC3, 8'h3C, 4'b0000);
        apply(8'hC3, 8'h3C, 4'b0001);
        // R2 carry boundary
        apply(255, 1, 4'b0010);
        apply(254, 1, 4'b0010);
        // R3 borrow boundary
        apply(0, 1, 4'b0011);
        apply(5, 5, 4'b0011);
        // R4 signed add limits
        apply(8'h7F, 8'h01, 4'b1010);
        apply(8'h80, 8'h80, 4'b1010);
        apply(8'hFF, 8'h01, 4'b1010);
        apply(8'hFE, 8'h01, 4'b1010);
        // R5 signed subtract limits
        apply(8'h80, 8'h01, 4'b1011);
        apply(8'h7F, 8'hFF, 4'b1011);
        apply(8'h00, 8'h80, 4'b1011);
        apply(8'h03, 8'h05, 4'b1011);
        // R7 named residues
        apply(8'hFF, 0, 4'b1100);
        apply(8'h80, 0, 4'b1100);
        // R8 unused codes
        apply(8'hFF, 8'hFF, 4'b0101);
        apply(8'hFF, 8'hFF, 4'b1111);
        apply(8'hFF, 8'hFF, 4'b1000);

        // R6, R7: every operand value in both residue modes
        for (int i = 0; i < 256; i++) apply(i, 255 - i, 4'b0100);
        for (int i = 0; i < 256; i++) apply(i, i, 4'b1100);

        // All codes, random operands, code changing each cycle
        for (int i = 0; i < 3000; i++)
            apply(int'($urandom_range(255)), int'($urandom_range(255)), 4'($urandom_range(15)));
        flush();

        // R9: reset in mid-run clears the outputs
        apply(255, 255, 4'b0010);
        flush();
        rst_n = 1'b0;
        @(negedge clk);
        exp_res = 0; exp_ovf = 0; exp_neg = 0;
        compare("R9");
        rst_n = 1'b1;
        apply(8'h10, 8'h20, 4'b0011);
        flush();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule